// File: doc/BRIEF.md
# Gated 13-bit Counter/Timer

This block is a 13-bit up-counter for a microcontroller peripheral set. Software sees the count as two byte registers: a high byte with the upper eight bits and a low byte with the lower five. A third byte register carries the control fields and the overflow flag. The count can advance on one of three sources: every system clock, a single-cycle prescaled tick supplied by logic outside the block, or falling edges on an external count pin.

Counting can also be gated by an external pin whose active level is programmable. With the gate enabled, the counter accumulates only while the pin is at its active level, so the time a pulse stays active can be measured in clock or tick units. When the count wraps from all ones to zero, a sticky overflow flag is set. An interrupt request follows the flag whenever the interrupt enable field is set. Several copies can be placed side by side, one per timer.

Top module: `gated_ctr13`

## Requirements
- R1: The count is 13 bits wide. Reading address 1 returns count bits 12..5. Reading address 0 returns count bits 4..0 in bits 4..0; software must mask bits 7..5 of that read.
- R2: Bits 7..5 of a write to address 0 have no effect on the count.
- R3: When the count advances from 0x1FFF, it becomes 0x0000 and the overflow flag is set. The flag appears on `ovf_flag` and in bit 7 of address 2. `irq` is high exactly while the flag is set and the interrupt enable field (address 2 bit 5) is 1.
- R4: With the source-select field (address 2 bit 2) at 1, the count advances once for each falling edge of `ext_cnt_in`. The pin passes through a two-flop synchronizer, so the count changes at the third rising clock edge after the pin falls.
- R5: With the source-select field at 0, the clock-select field (address 2 bit 3) chooses the source. At 1 the count advances on every clock. At 0 it advances only in cycles where `presc_tick` is high.
- R6: With the run field (address 2 bit 0) at 0, the count never advances, whatever the gate field, the gate pin and the source are.
- R7: With the gate field (address 2 bit 1) at 1, the count advances only while the synchronized `ext_gate_in` equals the polarity field (address 2 bit 4; 1 means active high). The gate pin is synchronized by two flops, so a change on the pin acts on the advance at the third edge.
- R8: The overflow flag stays set until a write to address 2 with bit 7 at 0. Writing bit 7 as 1 leaves the flag unchanged. If an overflow and a clearing write fall in the same cycle, the flag ends up set.
- R9: A write to address 0 or 1 takes effect at the next clock edge and replaces only its own bits. In that cycle the write takes priority over any advance.
- R10: After a synchronous reset, the count, all control fields and the flag are 0, and `irq` is low.
- R11: Bits 5..0 of address 2 read back as last written, and bit 6 reads 0. Address 3 reads as 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 low byte, 1 high byte, 2 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Combinational read data |
| ext_cnt_in | input | 1 | External count pin; counted on falling edges |
| ext_gate_in | input | 1 | External gate pin |
| presc_tick | input | 1 | Single-cycle prescaled count enable |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request, overflow qualified by enable |

## Verification
The embedded assertions check these properties on every cycle: the flag is set at every wrap, the count moves by at most one per cycle, the count holds while stopped or while the gate is inactive, the flag stays set until cleared, a high-byte write wins over an advance, control fields read back as written, and an edge pulse lasts one cycle. Some behaviours can only be shown by the bench scenarios, where a behavioural model predicts every read and output. These are the exact synchronizer latency on both pins, which source is chosen, the effect of gate polarity, and the rule that an overflow beats a clear in the same cycle. The same applies to a low-byte write ignoring its upper bits and to the interrupt mask.

// File: rtl/gctr13_pkg.sv
package gctr13_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int FLAG_BIT = 7;

    typedef enum logic [ADDR_W-1:0] {
        REG_LO  = 2'd0,
        REG_HI  = 2'd1,
        REG_CTL = 2'd2,
        REG_RSV = 2'd3
    } reg_sel_e;

    // Control fields, run at bit 0 up to irq_en at bit 5.
    typedef struct packed {
        logic irq_en;
        logic gate_pol;
        logic fast_clk;
        logic ext_sel;
        logic gate_en;
        logic run;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Pick the count pulse for this cycle from the three sources.
    function automatic logic tick_select(ctl_t c, logic fall, logic presc);
        logic t;
        if (c.ext_sel) begin
            t = fall;
        end else if (c.fast_clk) begin
            t = 1'b1;
        end else begin
            t = presc;
        end
        return t;
    endfunction

    // Run qualified by the optional hardware gate.
    function automatic logic count_enable(ctl_t c, logic gate_lvl);
        return c.run && (!c.gate_en || (gate_lvl == c.gate_pol));
    endfunction

endpackage

// File: rtl/gctr13_sync.sv
module gctr13_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q <= RST_VAL;
                end else begin
                    chain_q <= d;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q <= {STAGES{RST_VAL}};
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], d};
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gctr13_inputs.sv
module gctr13_inputs #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cnt_pin,
    input  logic gate_pin,
    output logic fall_pulse,
    output logic gate_lvl
);

    logic cnt_s;
    logic cnt_prev_q;

    gctr13_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cnt_sync (
        .clk (clk),
        .rst (rst),
        .d   (cnt_pin),
        .q   (cnt_s)
    );

    gctr13_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_gate_sync (
        .clk (clk),
        .rst (rst),
        .d   (gate_pin),
        .q   (gate_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_prev_q <= 1'b0;
        end else begin
            cnt_prev_q <= cnt_s;
        end
    end

    assign fall_pulse = cnt_prev_q & ~cnt_s;

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        fall_pulse |=> !fall_pulse); // R4

endmodule

// File: rtl/gctr13_regs.sv
module gctr13_regs
    import gctr13_pkg::*;
#(
    parameter int CNT_W = 13,
    parameter int LO_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              flag,
    output ctl_t              ctl,
    output logic              wr_lo,
    output logic              wr_hi,
    output logic              flag_clr,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int HI_W = CNT_W - LO_W;

    reg_sel_e wsel;
    reg_sel_e rsel;
    logic     wr_ctl;
    ctl_t     ctl_q;
    logic     unused_wr_bits;

    assign wsel     = reg_sel_e'(wr_addr);
    assign rsel     = reg_sel_e'(rd_addr);
    assign wr_lo    = wr_en && (wsel == REG_LO);
    assign wr_hi    = wr_en && (wsel == REG_HI);
    assign wr_ctl   = wr_en && (wsel == REG_CTL);
    assign flag_clr = wr_ctl && !wr_data[FLAG_BIT];

    assign unused_wr_bits = ^wr_data[FLAG_BIT-1:CTL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_ctl) begin
            ctl_q <= ctl_t'(wr_data[CTL_W-1:0]);
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rsel)
            REG_LO:  rd_data[LO_W-1:0] = cnt_val[LO_W-1:0];
            REG_HI:  rd_data[HI_W-1:0] = cnt_val[CNT_W-1:LO_W];
            REG_CTL: begin
                rd_data[CTL_W-1:0] = ctl_q;
                rd_data[FLAG_BIT]  = flag;
            end
            REG_RSV: rd_data = '0;
            default: rd_data = '0;
        endcase
    end

    assign ctl = ctl_q;

    AST_CTL_READBACK: assert property (@(posedge clk) disable iff (rst)
        wr_ctl |=> (ctl_q == $past(wr_data[CTL_W-1:0]))); // R11

endmodule

// File: rtl/gctr13_core.sv
module gctr13_core
    import gctr13_pkg::*;
#(
    parameter int CNT_W = 13,
    parameter int LO_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic              fall_pulse,
    input  logic              gate_lvl,
    input  logic              presc_tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              flag
);

    localparam int               HI_W    = CNT_W - LO_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             adv;
    logic             wr_any;
    logic             wrap;

    assign adv    = count_enable(ctl, gate_lvl) && tick_select(ctl, fall_pulse, presc_tick);
    assign wr_any = wr_lo || wr_hi;
    assign wrap   = adv && !wr_any && (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_any) begin
                if (wr_lo) begin
                    cnt_q[LO_W-1:0] <= wr_data[LO_W-1:0];
                end
                if (wr_hi) begin
                    cnt_q[CNT_W-1:LO_W] <= wr_data[HI_W-1:0];
                end
            end else if (adv) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (wrap) begin
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign cnt_val = cnt_q;
    assign flag    = flag_q;

    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!wr_any && adv && cnt_q == CNT_MAX) |=> (flag_q && cnt_q == '0)); // R3
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        !wr_any |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R5
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!ctl.run && !wr_any) |=> $stable(cnt_q)); // R6
    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (ctl.gate_en && gate_lvl != ctl.gate_pol && !wr_any) |=> $stable(cnt_q)); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !flag_clr) |=> flag_q); // R8
    AST_HI_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (cnt_q[CNT_W-1:LO_W] == $past(wr_data[HI_W-1:0]))); // R9

endmodule

// File: rtl/gated_ctr13.sv
module gated_ctr13
    import gctr13_pkg::*;
#(
    parameter int CNT_W       = 13,
    parameter int LO_W        = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              ext_cnt_in,
    input  logic              ext_gate_in,
    input  logic              presc_tick,
    output logic              ovf_flag,
    output logic              irq
);

    ctl_t             ctl;
    logic             fall_pulse;
    logic             gate_lvl;
    logic             wr_lo;
    logic             wr_hi;
    logic             flag_clr;
    logic [CNT_W-1:0] cnt_val;
    logic             flag;

    gctr13_inputs #(.SYNC_STAGES(SYNC_STAGES)) u_inputs (
        .clk        (clk),
        .rst        (rst),
        .cnt_pin    (ext_cnt_in),
        .gate_pin   (ext_gate_in),
        .fall_pulse (fall_pulse),
        .gate_lvl   (gate_lvl)
    );

    gctr13_regs #(.CNT_W(CNT_W), .LO_W(LO_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .cnt_val  (cnt_val),
        .flag     (flag),
        .ctl      (ctl),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .flag_clr (flag_clr),
        .rd_data  (rd_data)
    );

    gctr13_core #(.CNT_W(CNT_W), .LO_W(LO_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .fall_pulse (fall_pulse),
        .gate_lvl   (gate_lvl),
        .presc_tick (presc_tick),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .wr_data    (wr_data),
        .flag_clr   (flag_clr),
        .cnt_val    (cnt_val),
        .flag       (flag)
    );

    assign ovf_flag = flag;
    assign irq      = flag && ctl.irq_en;

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == REG_CTL && !wr_data[5]) |=> !irq); // R3

endmodule

// File: tb/gated_ctr13_tb_top.sv
`timescale 1ns/1ps
module gated_ctr13_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_cnt_in = 1'b0;
    logic       ext_gate_in = 1'b0;
    logic       presc_tick = 1'b0;
    logic       ovf_flag;
    logic       irq;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string cur_tag  = "R10";

    always #2 clk = ~clk;

    gated_ctr13 dut_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .ext_cnt_in  (ext_cnt_in),
        .ext_gate_in (ext_gate_in),
        .presc_tick  (presc_tick),
        .ovf_flag    (ovf_flag),
        .irq         (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    task automatic finish_up();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // Behavioural reference model, updated at each rising edge.
    int m_cnt  = 0;
    bit m_flag = 0;
    int m_ctl  = 0;
    bit chist[$] = '{0, 0, 0};
    bit ghist[$] = '{0, 0};

    always @(posedge clk) begin
        if (rst) begin
            m_cnt  = 0;
            m_flag = 0;
            m_ctl  = 0;
            chist  = '{0, 0, 0};
            ghist  = '{0, 0};
        end else begin
            bit fall, gact, en, tk, adv, wlo, whi, clr, wrp;
            fall = chist[2] && !chist[1];
            gact = (ghist[1] == m_ctl[4]);
            en   = m_ctl[0] && (!m_ctl[1] || gact);
            tk   = m_ctl[2] ? fall : (m_ctl[3] ? 1'b1 : presc_tick);
            adv  = en && tk;
            wlo  = wr_en && wr_addr == 2'd0;
            whi  = wr_en && wr_addr == 2'd1;
            clr  = wr_en && wr_addr == 2'd2 && !wr_data[7];
            wrp  = 0;
            if (wlo) begin
                m_cnt = (m_cnt & 32'h1FE0) | (int'(wr_data) & 32'h1F);
            end else if (whi) begin
                m_cnt = (m_cnt & 32'h1F) | (int'(wr_data) * 32);
            end else if (adv) begin
                if (m_cnt == 32'h1FFF) begin
                    m_cnt = 0;
                    wrp   = 1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (wrp) m_flag = 1;
            else if (clr) m_flag = 0;
            if (wr_en && wr_addr == 2'd2) m_ctl = int'(wr_data) & 32'h3F;
            chist.push_front(ext_cnt_in);
            void'(chist.pop_back());
            ghist.push_front(ext_gate_in);
            void'(ghist.pop_back());
        end
    end

    // Per-cycle comparison shortly after each rising edge.
    always @(posedge clk) begin
        #1;
        if (!done) begin
            string t;
            t = rst ? "R10" : cur_tag;
            case (rd_addr)
                2'd0: chk({t, " R1 low byte"}, rd_data & 8'h1F, m_cnt & 32'h1F);
                2'd1: chk({t, " R1 high byte"}, rd_data, (m_cnt >> 5) & 32'hFF);
                2'd2: chk({t, " R11 control"}, rd_data, (m_flag ? 32'h80 : 32'h0) | m_ctl);
                default: chk({t, " R11 reserved"}, rd_data, 0);
            endcase
            chk({t, " R8 flag"}, ovf_flag, m_flag);
            chk({t, " R3 irq"}, irq, m_flag && m_ctl[5]);
        end
    end

    always @(negedge clk) rd_addr <= rd_addr + 2'd1;

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            finish_up();
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cur_tag = "R10";
        idle(4);
        chk("R10 flag after reset", ovf_flag, 0);

        cur_tag = "R11";
        wr(2'd2, 8'h7A);
        wr(2'd3, 8'hFF);
        idle(6);

        cur_tag = "R6";
        wr(2'd2, 8'h1E);
        idle(8);

        cur_tag = "R5";
        wr(2'd2, 8'h09);
        idle(20);

        cur_tag = "R9";
        wr(2'd1, 8'hAB);
        wr(2'd0, 8'h07);
        idle(5);

        cur_tag = "R2";
        wr(2'd2, 8'h80);
        wr(2'd0, 8'hE3);
        idle(5);

        cur_tag = "R1";
        wr(2'd1, 8'h5A);
        wr(2'd0, 8'h15);
        idle(6);

        cur_tag = "R5";
        wr(2'd2, 8'h01);
        for (int i = 0; i < 40; i++) begin
            presc_tick = (i % 3 == 0);
            @(negedge clk);
        end
        presc_tick = 1'b0;

        cur_tag = "R3";
        wr(2'd2, 8'h80);
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h1A);
        wr(2'd2, 8'h89);
        idle(10);
        chk("R3 flag after wrap", ovf_flag, 1);
        chk("R3 irq masked", irq, 0);
        wr(2'd2, 8'hA9);
        idle(1);
        chk("R3 irq raised", irq, 1);

        cur_tag = "R8";
        wr(2'd2, 8'hA9);
        chk("R8 write of one keeps flag", ovf_flag, 1);
        wr(2'd2, 8'h29);
        chk("R8 clear", ovf_flag, 0);
        wr(2'd2, 8'h80);
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h1F);
        wr(2'd2, 8'h09);
        wr(2'd2, 8'h09);
        chk("R8 overflow beats clear", ovf_flag, 1);
        idle(3);

        cur_tag = "R4";
        wr(2'd2, 8'h80);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h85);
        for (int i = 0; i < 60; i++) begin
            ext_cnt_in = (i < 30) ? ((i % 5) < 3) : (i % 2 == 0);
            @(negedge clk);
        end
        ext_cnt_in = 1'b0;
        idle(5);

        cur_tag = "R7";
        wr(2'd2, 8'h9B);
        for (int i = 0; i < 40; i++) begin
            ext_gate_in = (i % 7) < 3;
            @(negedge clk);
        end
        wr(2'd2, 8'h8B);
        for (int i = 0; i < 40; i++) begin
            ext_gate_in = (i % 9) < 4;
            @(negedge clk);
        end
        cur_tag = "R6";
        wr(2'd2, 8'h8A);
        for (int i = 0; i < 12; i++) begin
            ext_gate_in = i[0];
            @(negedge clk);
        end
        idle(4);
        finish_up();
    end

endmodule